// File: doc/BRIEF.md
# Lane IDLE Rate-Matching Controller

This block sits on one receive lane. It holds that lane's elastic buffer and keeps the buffer from running dry or overflowing. The write side deposits characters at the lane's recovered rate. The read side drains one character per read tick at the common rate. When the fill level drifts near either end, the block drops an IDLE character or repeats one at the buffer output. It never drops or repeats a data character.

The block can run with rate matching disabled, within its own lane, or across lanes. In the cross-lane setting, one lane acts as the deciding lane. Its pending request appears on `sync_out`, and that output is wired to the `sync_in` of every lane in the aligned group, including the deciding lane itself. Because the lanes are aligned, every lane reaches the same IDLE in the same read tick. Every lane therefore applies the same drop or repeat at the same character position, and the lanes stay aligned.

The mode comes from `lock_bypass` together with `sync_src`:

| `lock_bypass` | `sync_src` | Mode |
|---|---|---|
| 1 | any | off |
| 0 | 2'b00 (input held low) | off |
| 0 | 2'b11 | off |
| 0 | 2'b01 (own sync output) | within this lane |
| 0 | 2'b10 (another lane's sync output) | across lanes |

A request code uses 2'b00 for none, 2'b01 for repeat, and 2'b10 for drop.

Top module: `rm_lane_ctrl`

## Requirements
- R1: When the buffer fill is DEPTH-2 or more, `sync_out` becomes 2'b10 (drop request). The new value is visible in the cycle after the fill reaches that level.
- R2: When the buffer fill is 2 or less, `sync_out` becomes 2'b01 (repeat request). The new value is visible one cycle later.
- R3: Data characters (`wr_idle`=0) are delivered unchanged, in write order. None is ever dropped or repeated, even while a request is active.
- R4: A drop applies only when the character at the buffer head is an IDLE. That IDLE is skipped, the next stored character is delivered in the same read tick, and `del_pulse` is high with it.
- R5: A repeat applies only when the character at the buffer head is an IDLE. That IDLE is delivered twice in consecutive read ticks, and `ins_pulse` is high with the first copy.
- R6: A request waits for the next IDLE at the buffer head. Each request causes exactly one adjustment, even when the request code stays asserted across several IDLEs.
- R7: With `lock_bypass` high, no adjustment is made, both pulses stay low, and `sync_out` reads 2'b00.
- R8: With `sync_src` at 2'b00, rate matching is off and the stream passes through unchanged.
- R9: With `sync_src` at 2'b01, the block acts on its own request and ignores `sync_in`.
- R10: With `sync_src` at 2'b10, the block acts on the code at `sync_in` and ignores its own request.
- R11: Output characters and both pulses are registered. Each appears one cycle after the read tick that produced it, and each pulse lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_bypass | input | 1 | High disables rate matching |
| sync_src | input | 2 | Source of the sync input (00 held low, 01 own, 10 another lane) |
| sync_in | input | 2 | Request code broadcast by the deciding lane |
| sync_out | output | 2 | This lane's pending request code |
| wr_en | input | 1 | Write one character into the buffer |
| wr_data | input | DW | Character value |
| wr_idle | input | 1 | Character is an IDLE |
| rd_en | input | 1 | Read tick of the common rate |
| out_valid | output | 1 | Output character valid |
| out_data | output | DW | Output character value |
| out_idle | output | 1 | Output character is an IDLE |
| ins_pulse | output | 1 | One IDLE was repeated |
| del_pulse | output | 1 | One IDLE was dropped |

## Verification
A request shows on `sync_out` two clock edges after the write that brought the fill to a threshold. The first edge updates the fill count and the second registers the request. The bench therefore samples `sync_out` at the falling edge after each of those two edges and expects no change at the first sample. Each output character and its pulse appear one edge after the read tick that produced them. The bench records the stream at every falling edge and compares it, in order, with the sequence worked out from the requirements. The pulse counts are taken over the same window.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_DUP  = 2'b01,
    CMD_DEL  = 2'b10
  } rm_cmd_t;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_LOCAL = 2'b01,
    MODE_PEER  = 2'b10
  } rm_mode_t;

  localparam logic [1:0] SRC_LOW  = 2'b00;
  localparam logic [1:0] SRC_OWN  = 2'b01;
  localparam logic [1:0] SRC_PEER = 2'b10;
endpackage

// File: rtl/rm_fifo.sv
module rm_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW:0]   wr_word,
  input  logic [1:0]    pop_cnt,
  output logic [DW:0]   head0,
  output logic [DW:0]   head1,
  output logic [CW-1:0] fill
);
  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          acc;

  assign acc = wr_en && (fill != CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= wr_word;
  end

  assign head0 = mem[rp];
  assign head1 = mem[rp + AW'(1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (acc) wp <= wp + AW'(1);
      rp   <= rp + AW'(pop_cnt);
      fill <= fill + CW'(acc) - CW'(pop_cnt);
    end
  end

  assert_pop_within_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (CW'(pop_cnt) <= fill));
endmodule

// File: rtl/rm_decide.sv
module rm_decide
  import rm_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  rm_mode_t      mode,
  input  logic [CW-1:0] fill,
  input  logic          apply_any,
  output rm_cmd_t       req
);
  localparam logic [CW-1:0] HI = CW'(DEPTH - 2);
  localparam logic [CW-1:0] LO = CW'(2);

  always_ff @(posedge clk) begin
    if (rst || mode == MODE_OFF) req <= CMD_NONE;
    else if (apply_any)          req <= CMD_NONE;
    else if (fill >= HI)         req <= CMD_DEL;
    else if (fill <= LO)         req <= CMD_DUP;
  end

  assert_req_code_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req));
  assert_off_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> (req == CMD_NONE));
endmodule

// File: rtl/rm_apply.sv
module rm_apply
  import rm_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  rm_mode_t      mode,
  input  rm_cmd_t       own_req,
  input  rm_cmd_t       peer_req,
  input  logic          rd_en,
  input  logic          head_idle,
  input  logic [CW-1:0] fill,
  output logic          do_del,
  output logic          do_dup,
  output logic [1:0]    pop_cnt
);
  rm_cmd_t cmd_src;
  logic    mask, eligible;

  always_comb begin
    case (mode)
      MODE_LOCAL: cmd_src = own_req;
      MODE_PEER:  cmd_src = peer_req;
      default:    cmd_src = CMD_NONE;
    endcase
  end

  assign eligible = rd_en && !mask && head_idle && (fill != '0);
  assign do_del   = eligible && (cmd_src == CMD_DEL) && (fill >= CW'(2));
  assign do_dup   = eligible && (cmd_src == CMD_DUP);

  always_comb begin
    if (!rd_en || fill == '0) pop_cnt = 2'd0;
    else if (do_del)          pop_cnt = 2'd2;
    else if (do_dup)          pop_cnt = 2'd0;
    else                      pop_cnt = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                       mask <= 1'b0;
    else if (do_del || do_dup)     mask <= 1'b1;
    else if (cmd_src == CMD_NONE)  mask <= 1'b0;
  end

  assert_one_per_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    (do_del || do_dup) |=> !(do_del || do_dup));
  assert_excl_adjust_R4: assert property (@(posedge clk) disable iff (rst)
    !(do_del && do_dup));
endmodule

// File: rtl/rm_lane_ctrl.sv
module rm_lane_ctrl
  import rm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_bypass,
  input  logic [1:0]    sync_src,
  input  logic [1:0]    sync_in,
  output logic [1:0]    sync_out,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_idle,
  input  logic          rd_en,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_idle,
  output logic          ins_pulse,
  output logic          del_pulse
);
  rm_mode_t      mode;
  rm_cmd_t       req;
  logic [DW:0]   head0, head1, sel;
  logic [CW-1:0] fill;
  logic [1:0]    pop_cnt;
  logic          do_del, do_dup;

  always_comb begin
    if (lock_bypass)               mode = MODE_OFF;
    else if (sync_src == SRC_OWN)  mode = MODE_LOCAL;
    else if (sync_src == SRC_PEER) mode = MODE_PEER;
    else                           mode = MODE_OFF;
  end

  rm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word({wr_idle, wr_data}),
    .pop_cnt(pop_cnt), .head0(head0), .head1(head1), .fill(fill)
  );

  rm_decide #(.DEPTH(DEPTH)) u_decide (
    .clk(clk), .rst(rst), .mode(mode), .fill(fill),
    .apply_any(do_del || do_dup), .req(req)
  );

  rm_apply #(.DEPTH(DEPTH)) u_apply (
    .clk(clk), .rst(rst), .mode(mode), .own_req(req),
    .peer_req(rm_cmd_t'(sync_in)), .rd_en(rd_en), .head_idle(head0[DW]),
    .fill(fill), .do_del(do_del), .do_dup(do_dup), .pop_cnt(pop_cnt)
  );

  assign sync_out = req;
  assign sel      = do_del ? head1 : head0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_idle  <= 1'b0;
      ins_pulse <= 1'b0;
      del_pulse <= 1'b0;
    end else begin
      out_valid <= rd_en && (fill != '0);
      ins_pulse <= do_dup;
      del_pulse <= do_del;
      if (rd_en && fill != '0) begin
        out_data <= sel[DW-1:0];
        out_idle <= sel[DW];
      end
    end
  end

  assert_dup_is_idle_R5: assert property (@(posedge clk) disable iff (rst)
    ins_pulse |-> (out_idle && out_valid));
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
    (ins_pulse || del_pulse) |=> !(ins_pulse || del_pulse));
  assert_off_no_adjust_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> !(ins_pulse || del_pulse));
endmodule

// File: tb/sim_rm_lane_ctrl.sv
`timescale 1ns/1ps
module sim_rm_lane_ctrl;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic lock_bypass = 1'b1;
  logic [1:0] sync_src = 2'b01, sync_in = 2'b00;
  logic [1:0] sync_out;
  logic wr_en = 1'b0, wr_idle = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic out_valid, out_idle, ins_pulse, del_pulse;
  logic [DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [DW:0] cap [64];
  logic [DW:0] exp_s [64];
  int cap_n = 0, ins_n = 0, del_n = 0, exp_n = 0;

  always #2 clk = ~clk;

  rm_lane_ctrl #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .lock_bypass(lock_bypass), .sync_src(sync_src),
    .sync_in(sync_in), .sync_out(sync_out), .wr_en(wr_en), .wr_data(wr_data),
    .wr_idle(wr_idle), .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data),
    .out_idle(out_idle), .ins_pulse(ins_pulse), .del_pulse(del_pulse)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && cap_n < 64) begin
        cap[cap_n] = {out_idle, out_data};
        cap_n++;
      end
      if (ins_pulse) ins_n++;
      if (del_pulse) del_n++;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clr();
    cap_n = 0; ins_n = 0; del_n = 0; exp_n = 0;
  endtask

  task automatic add_exp(input logic idle, input logic [DW-1:0] d);
    exp_s[exp_n] = {idle, d};
    exp_n++;
  endtask

  task automatic push(input logic idle, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idle = idle; wr_data = d;
  endtask

  task automatic stop_wr();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_n(input int n);
    @(negedge clk);
    rd_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_stream(input string req);
    chk({req, " stream length"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk({req, " stream char"}, int'(cap[i]), int'(exp_s[i]));
  endtask

  task automatic go_off();
    @(negedge clk);
    lock_bypass = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 bypass clears request", int'(sync_out), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset out_valid", int'(out_valid), 0);
    chk("R11 reset pulses", int'(ins_pulse | del_pulse), 0);
    chk("R7 reset sync_out", int'(sync_out), 0);
  endtask

  // R1 R4 R6 R3: drop of one IDLE under own-lane mode
  task automatic t_delete();
    clr();
    sync_src = 2'b01; sync_in = 2'b00;
    @(negedge clk); lock_bypass = 1'b0;
    push(1'b0, 8'h10); add_exp(1'b0, 8'h10);
    push(1'b0, 8'h11); add_exp(1'b0, 8'h11);
    push(1'b1, 8'hBC);
    for (int i = 0; i < 11; i++) begin
      push(1'b0, 8'h12 + DW'(i)); add_exp(1'b0, 8'h12 + DW'(i));
    end
    stop_wr();
    chk("R1 no early drop request", int'(sync_out), 1);
    @(negedge clk);
    chk("R1 drop request after fill 14", int'(sync_out), 2);
    read_n(16);
    chk_stream("R4");
    chk("R4 drop pulses", del_n, 1);
    chk("R6 no repeat without IDLE", ins_n, 0);
    go_off();
  endtask

  // R2 R5 R9: repeat of one IDLE; sync_in ignored in own-lane mode
  task automatic t_dup();
    clr();
    sync_src = 2'b01; sync_in = 2'b10;
    @(negedge clk); lock_bypass = 1'b0;
    @(negedge clk);
    chk("R2 repeat request at low fill", int'(sync_out), 1);
    push(1'b1, 8'hBC); push(1'b0, 8'h21); push(1'b0, 8'h22);
    stop_wr();
    add_exp(1'b1, 8'hBC); add_exp(1'b1, 8'hBC);
    add_exp(1'b0, 8'h21); add_exp(1'b0, 8'h22);
    read_n(6);
    chk_stream("R5");
    chk("R5 repeat pulses", ins_n, 1);
    chk("R9 peer drop code ignored", del_n, 0);
    go_off();
    sync_in = 2'b00;
  endtask

  // R7: bypass keeps stream untouched at high fill
  task automatic t_bypass();
    clr();
    sync_src = 2'b01;
    push(1'b0, 8'h30); add_exp(1'b0, 8'h30);
    push(1'b1, 8'hBC); add_exp(1'b1, 8'hBC);
    for (int i = 0; i < 12; i++) begin
      push(1'b0, 8'h31 + DW'(i)); add_exp(1'b0, 8'h31 + DW'(i));
    end
    stop_wr();
    @(negedge clk);
    chk("R7 no request while bypassed", int'(sync_out), 0);
    read_n(16);
    chk_stream("R7");
    chk("R7 no pulses", ins_n + del_n, 0);
  endtask

  // R8: sync input held low
  task automatic t_tied();
    clr();
    sync_src = 2'b00;
    @(negedge clk); lock_bypass = 1'b0;
    push(1'b1, 8'hBC); push(1'b0, 8'h41); push(1'b0, 8'h42);
    stop_wr();
    add_exp(1'b1, 8'hBC); add_exp(1'b0, 8'h41); add_exp(1'b0, 8'h42);
    chk("R8 no request when held low", int'(sync_out), 0);
    read_n(5);
    chk_stream("R8");
    chk("R8 no pulses", ins_n + del_n, 0);
    go_off();
  endtask

  // R10 R6: peer drop code applied once, own repeat request ignored
  task automatic t_peer();
    clr();
    sync_src = 2'b10;
    @(negedge clk); lock_bypass = 1'b0;
    push(1'b0, 8'h51); push(1'b1, 8'hBC); push(1'b1, 8'hBD); push(1'b0, 8'h52);
    stop_wr();
    sync_in = 2'b10;
    add_exp(1'b0, 8'h51); add_exp(1'b1, 8'hBD); add_exp(1'b0, 8'h52);
    read_n(6);
    chk_stream("R10");
    chk("R10 one drop from peer", del_n, 1);
    chk("R10 own repeat ignored", ins_n, 0);
    sync_in = 2'b00;
    go_off();
  endtask

  // R3 R6: peer repeat code with data head, then with two IDLEs
  task automatic t_data();
    clr();
    sync_src = 2'b10;
    @(negedge clk); lock_bypass = 1'b0;
    sync_in = 2'b01;
    push(1'b0, 8'h61); push(1'b0, 8'h62); push(1'b0, 8'h63);
    stop_wr();
    add_exp(1'b0, 8'h61); add_exp(1'b0, 8'h62); add_exp(1'b0, 8'h63);
    read_n(5);
    chk_stream("R3");
    chk("R3 data never repeated", ins_n + del_n, 0);
    sync_in = 2'b00;
    @(negedge clk);
    clr();
    push(1'b1, 8'hBC); push(1'b1, 8'hBD);
    stop_wr();
    sync_in = 2'b01;
    add_exp(1'b1, 8'hBC); add_exp(1'b1, 8'hBC); add_exp(1'b1, 8'hBD);
    read_n(5);
    chk_stream("R6");
    chk("R6 one repeat per held code", ins_n, 1);
    sync_in = 2'b00;
    go_off();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_delete();
    t_dup();
    t_bypass();
    t_tied();
    t_peer();
    t_data();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule